// File: doc/BRIEF.md
# PLL Bypass and Lock-Loss Clock Selector

This block picks which of two clocks drives a shared output: the reference clock or the output of a PLL. Software chooses through a small control register. The block hands the output over between the two sources without glitches. It also watches the PLL lock indication. When lock goes away and automatic fallback is enabled, the block moves the output back to the reference clock by itself. It records that this happened in a sticky status bit, which software clears by writing 1 to it.

Out of reset the output runs from the reference clock, and the PLL is held disabled. The expected bring-up sequence is:
- enable the PLL;
- wait until the status register reports lock;
- clear the bypass bit.

Register access is a simple single-cycle write strobe with a combinational read, both in the reference clock domain. The lock input is asynchronous and is brought into the reference domain by a flop chain. The changeover works as a handshake between two legs, one per clock domain. Each leg switches its own gate only on the falling edge of its own clock, and only once the other leg's gate is seen to be off.

Top module: `pll_clk_selector`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x8001_0000: bypass at bit 31 is 1, fallback enable at bit 16 is 1, PLL enable at bit 15 is 0. The output follows the reference clock.
- R2: The `pll_en_o` output takes the value of control bit 15 in the cycle after a write to the control register.
- R3: Status register (offset 0x4) bit 0 shows the PLL lock input after synchronization into the reference domain. It reflects a level that has been held for at least three reference cycles.
- R4: With bypass clear and lock present, the output carries the PLL clock. Status bit 2 then reads 1.
- R5: While bypass is set, the output carries the reference clock whatever the lock state is. Status bit 2 then reads 0.
- R6: If lock drops while fallback is enabled, the output returns to the reference clock. The bypass bit keeps its software value.
- R7: After a fallback, the PLL clock is selected again once lock returns, provided bypass is still clear.
- R8: A fallback caused by lock loss sets status bit 1. Writing 1 to that bit clears it, and writing 0 to it has no effect.
- R9: With fallback disabled, loss of lock neither changes the selected clock nor sets status bit 1.
- R10: The two source gates are never both open. The output has no high or low phase shorter than the shorter half-period of the two sources.
- R11: Control bits other than 31, 16 and 15 read 0 whatever was written to them. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register interface |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each clock domain |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pll_en_o | output | 1 | Enable to the PLL |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
The bench identifies the source that drives `clk_out` by counting output edges over a fixed window. It also times every output phase. A switch that was not glitch-free would show a short pulse whenever the source changes. A design that let the automatic fallback overwrite the bypass bit would read back a changed control value. A design that did not re-arm after lock returns would stay on the reference clock. The sticky bit is probed with a write of 0 and then a write of 1, which catches a clear on any write. Lock loss is repeated with fallback disabled to catch a fallback path that ignores its enable.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
// Package: register offsets and bit positions shared by the selector.
package clksel_pkg;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 4'h0;
    localparam logic [ADDR_W-1:0] STAT_OFS = 4'h4;
    // control register bit positions
    localparam int BIT_BYPASS  = 31;
    localparam int BIT_FB_EN   = 16;
    localparam int BIT_PLL_EN  = 15;
    // status register bit positions
    localparam int BIT_LOCK    = 0;
    localparam int BIT_STICKY  = 1;
    localparam int BIT_ON_PLL  = 2;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Module: clksel_sync
// Flop chain that brings a single asynchronous bit into the clk domain.
// Assumes STAGES >= 1; reset is synchronous and active low.
module clksel_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the input through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
// Module: clksel_regs
// Control/status registers plus the selection decision, all in the
// reference clock domain. Assumes lock_s and on_pll_s are already
// synchronized into this domain.
module clksel_regs
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_s,
    input  logic              on_pll_s,
    output logic [DATA_W-1:0] rdata,
    output logic              bypass,
    output logic              fb_en,
    output logic              pll_en,
    output logic              sticky,
    output logic              want_pll
);
    logic lock_q;
    logic ctrl_hit;
    logic stat_hit;
    logic fall_evt;

    assign ctrl_hit = wr && (addr == CTRL_OFS);
    assign stat_hit = wr && (addr == STAT_OFS);

    // control register bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass <= 1'b1;
            fb_en  <= 1'b1;
            pll_en <= 1'b0;
        end else if (ctrl_hit) begin
            bypass <= wdata[BIT_BYPASS];
            fb_en  <= wdata[BIT_FB_EN];
            pll_en <= wdata[BIT_PLL_EN];
        end
    end

    // previous lock level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_s;
    end

    // a fallback occurs when lock falls while fallback is armed and the PLL was requested
    assign fall_evt = fb_en && !bypass && lock_q && !lock_s;

    // sticky lock-loss record; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                         sticky <= 1'b0;
        else if (fall_evt)                  sticky <= 1'b1;
        else if (stat_hit && wdata[BIT_STICKY]) sticky <= 1'b0;
    end

    // source request: PLL only when not bypassed and not held off by lock loss
    always_comb begin
        want_pll = !bypass && !(fb_en && !lock_s);
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == CTRL_OFS) begin
            rdata[BIT_BYPASS] = bypass;
            rdata[BIT_FB_EN]  = fb_en;
            rdata[BIT_PLL_EN] = pll_en;
        end else if (addr == STAT_OFS) begin
            rdata[BIT_LOCK]   = lock_s;
            rdata[BIT_STICKY] = sticky;
            rdata[BIT_ON_PLL] = on_pll_s;
        end
    end
endmodule

// File: rtl/clksel_leg.sv
`timescale 1ns/1ps
// Module: clksel_leg
// One side of the glitch-free switch. The request, qualified by the other
// side's gate being closed, is synchronized on rising edges of this side's
// clock; the gate itself changes only on the falling edge, while the
// clock is low. Assumes SYNC_STAGES >= 2.
module clksel_leg #(
    parameter int   SYNC_STAGES = 2,
    parameter logic ON_AT_RESET = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_gate,
    output logic gate
);
    localparam int RISE_STAGES = SYNC_STAGES - 1;

    logic armed;

    clksel_sync #(
        .STAGES    (RISE_STAGES),
        .RESET_VAL (ON_AT_RESET)
    ) u_arm (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (want && !other_gate),
        .q     (armed)
    );

    // gate update on the falling edge of this side's clock
    always_ff @(negedge src_clk) begin
        if (!rst_n) gate <= ON_AT_RESET;
        else        gate <= armed;
    end
endmodule

// File: rtl/pll_clk_selector.sv
`timescale 1ns/1ps
// Module: pll_clk_selector
// Top: register block, lock synchronizer, two-legged glitch-free switch.
// Assumes rst_n is held low for several cycles of both clocks so both
// domains see it.
module pll_clk_selector
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              pll_clk,
    input  logic              rst_n,
    input  logic              pll_lock,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pll_en_o,
    output logic              clk_out
);
    logic lock_s;
    logic on_pll_s;
    logic bypass;
    logic fb_en;
    logic sticky;
    logic want_pll;
    logic ref_gate;
    logic pll_gate;

    clksel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_lock_sync (
        .clk (ref_clk), .rst_n (rst_n), .d (pll_lock), .q (lock_s)
    );

    clksel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_src_sync (
        .clk (ref_clk), .rst_n (rst_n), .d (pll_gate), .q (on_pll_s)
    );

    clksel_regs u_regs (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .lock_s   (lock_s),
        .on_pll_s (on_pll_s),
        .rdata    (reg_rdata),
        .bypass   (bypass),
        .fb_en    (fb_en),
        .pll_en   (pll_en_o),
        .sticky   (sticky),
        .want_pll (want_pll)
    );

    clksel_leg #(.SYNC_STAGES(SYNC_STAGES), .ON_AT_RESET(1'b1)) u_ref_leg (
        .src_clk    (ref_clk),
        .rst_n      (rst_n),
        .want       (!want_pll),
        .other_gate (pll_gate),
        .gate       (ref_gate)
    );

    clksel_leg #(.SYNC_STAGES(SYNC_STAGES), .ON_AT_RESET(1'b0)) u_pll_leg (
        .src_clk    (pll_clk),
        .rst_n      (rst_n),
        .want       (want_pll),
        .other_gate (ref_gate),
        .gate       (pll_gate)
    );

    // combine the gated clocks; at most one gate is open
    assign clk_out = (ref_clk && ref_gate) || (pll_clk && pll_gate);
endmodule

// File: rtl/clksel_checker.sv
`timescale 1ns/1ps
// Module: clksel_checker
// Properties on the selector, attached to the top by bind.
module clksel_checker
    import clksel_pkg::*;
(
    input logic              ref_clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              pll_en_o,
    input logic              ref_gate,
    input logic              pll_gate,
    input logic              lock_s,
    input logic              want_pll,
    input logic              bypass,
    input logic              fb_en,
    input logic              sticky
);
    assert_single_gate_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(ref_gate && pll_gate));

    assert_bypass_ref_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        bypass |-> !want_pll);

    assert_fallback_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fb_en && !lock_s) |-> !want_pll);

    assert_sticky_set_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (fb_en && !bypass && $fell(lock_s)) |=> sticky);

    assert_sticky_hold_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (sticky && !(reg_wr && reg_addr == STAT_OFS && reg_wdata[BIT_STICKY])) |=> sticky);

    assert_pll_en_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CTRL_OFS) |=> (pll_en_o == $past(reg_wdata[BIT_PLL_EN])));
endmodule

bind pll_clk_selector clksel_checker u_chk (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pll_en_o  (pll_en_o),
    .ref_gate  (ref_gate),
    .pll_gate  (pll_gate),
    .lock_s    (lock_s),
    .want_pll  (want_pll),
    .bypass    (bypass),
    .fb_en     (fb_en),
    .sticky    (sticky)
);

// File: tb/pll_clk_selector_bench.sv
`timescale 1ns/1ps
module pll_clk_selector_bench;
    logic        ref_clk = 1'b0;
    logic        pll_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        pll_lock = 1'b0;
    logic        reg_wr  = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        pll_en_o;
    logic        clk_out;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    int glitch_cnt = 0;
    bit mon_en = 1'b0;
    realtime last_t = 0.0;

    always #10.0 ref_clk = ~ref_clk;   // 50 MHz reference
    always #3.5  pll_clk = ~pll_clk;   // PLL model

    pll_clk_selector u_pll_clk_selector (
        .ref_clk (ref_clk), .pll_clk (pll_clk), .rst_n (rst_n),
        .pll_lock (pll_lock), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pll_en_o (pll_en_o), .clk_out (clk_out)
    );

    always @(posedge clk_out) edge_cnt++;

    // phase-width monitor for the output clock
    always @(clk_out) begin
        if (mon_en && ($realtime - last_t) < 3.0) glitch_cnt++;
        last_t = $realtime;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge ref_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge ref_clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge ref_clk);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge ref_clk);
    endtask

    // identify the source by edge rate: 1 = PLL, 0 = reference
    task automatic check_src(input string req, input logic exp_pll);
        int n0, n;
        logic got;
        n0 = edge_cnt;
        #1000;
        n = edge_cnt - n0;
        got = (n >= 130);
        checks++;
        if (got !== exp_pll || (!got && (n < 48 || n > 52)) || (got && n > 146)) begin
            fails++;
            $display("FAIL %s: actual source %0d (%0d edges) expected source %0d",
                     req, got, n, exp_pll);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(4'h0, d);
        check("R1 ctrl reset", d, 32'h8001_0000);
        check("R1 pll_en reset", {31'b0, pll_en_o}, 32'h0);
        check_src("R1 ref after reset", 1'b0);
        reg_read(4'h8, d);
        check("R11 unmapped read", d, 32'h0);
    endtask

    task automatic t_lock_status;
        logic [31:0] d;
        pll_lock = 1'b1;
        settle(4);
        reg_read(4'h4, d);
        check("R3 lock bit", d & 32'h1, 32'h1);
    endtask

    task automatic t_enable_bypassed;
        logic [31:0] d;
        reg_write(4'h0, 32'hFFFF_FFFF);
        #1;
        check("R2 pll_en out", {31'b0, pll_en_o}, 32'h1);
        reg_read(4'h0, d);
        check("R11 ctrl readback", d, 32'h8001_8000);
        settle(10);
        check_src("R5 bypass keeps ref", 1'b0);
        reg_read(4'h4, d);
        check("R5 status src bit", d & 32'h4, 32'h0);
    endtask

    task automatic t_select_pll;
        logic [31:0] d;
        reg_write(4'h0, 32'h0001_8000);
        settle(10);
        check_src("R4 pll selected", 1'b1);
        reg_read(4'h4, d);
        check("R4 status src bit", d & 32'h4, 32'h4);
    endtask

    task automatic t_fallback;
        logic [31:0] d;
        pll_lock = 1'b0;
        settle(10);
        check_src("R6 fallback to ref", 1'b0);
        reg_read(4'h0, d);
        check("R6 bypass untouched", d, 32'h0001_8000);
        reg_read(4'h4, d);
        check("R8 sticky set", d, 32'h0000_0002);
        reg_write(4'h4, 32'h0);
        reg_read(4'h4, d);
        check("R8 write 0 keeps", d & 32'h2, 32'h2);
        reg_write(4'h4, 32'h2);
        reg_read(4'h4, d);
        check("R8 write 1 clears", d & 32'h2, 32'h0);
    endtask

    task automatic t_relock;
        pll_lock = 1'b1;
        settle(10);
        check_src("R7 reselect pll", 1'b1);
    endtask

    task automatic t_no_fallback;
        logic [31:0] d;
        reg_write(4'h0, 32'h0000_8000);
        pll_lock = 1'b0;
        settle(10);
        check_src("R9 stays on pll", 1'b1);
        reg_read(4'h4, d);
        check("R9 no sticky", d & 32'h2, 32'h0);
    endtask

    task automatic t_bypass_back;
        reg_write(4'h0, 32'h8000_8000);
        settle(10);
        check_src("R5 bypass to ref", 1'b0);
        check("R10 no short phase", glitch_cnt, 0);
    endtask

    initial begin
        repeat (20) @(posedge ref_clk);
        @(negedge ref_clk);
        rst_n = 1'b1;
        settle(4);
        mon_en = 1'b1;
        t_reset();
        t_lock_status();
        t_enable_bypassed();
        t_select_pll();
        t_fallback();
        t_relock();
        t_no_fallback();
        t_bypass_back();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule